// File: doc/BRIEF.md
# Signed Bounds Check Trap Unit

This execution unit decides whether a signed test value lies inside its permitted range and raises a bounds-check trap when it does not. It has two modes. In single-bound mode the permitted range runs from zero up to an upper bound. In dual-bound mode it runs from a lower bound up to an upper bound. The value and the bounds arrive already sign-extended to the datapath width. All comparisons are signed two's-complement.

The unit also produces the condition flags that such a check leaves behind. It matches the flag values measured on real hardware, not the nominally undefined ones. That includes bound pairs that wrap around, where the lower bound is greater than the upper bound.

A start strobe launches one check. One cycle later the unit pulses done and presents the following:
- the updated flags, which are written back whether or not a trap occurs;
- a trap request with a fixed vector code;
- the return PC, which is the instruction address plus the instruction length for the mode.

Operand fetch, sign extension and exception entry are handled elsewhere.

Top module: `bound_trap_unit`

## Requirements
- R1: After reset, done, trap, trap_vec, flags_out and ret_pc are all zero.
- R2: done is high in the cycle after a cycle with start high, and low in the cycle after a cycle with start low.
- R3: The flag vector uses bit 4 = X, 3 = N, 2 = Z, 1 = V, 0 = C. In single-bound mode (dual_mode = 0), N becomes 1 exactly when the value is negative.
- R4: In single-bound mode, C is handled as follows:
  - if the upper bound is non-negative, C = (value < 0) or (value > upper);
  - if the upper bound is negative, C = (value > upper) and (value < 0).
- R5: In single-bound mode, trap is raised exactly when value < 0 or value > upper, whatever C is. The lower bound has no effect in this mode.
- R6: In dual-bound mode (dual_mode = 1), Z becomes 1 exactly when the value equals the lower bound or the upper bound.
- R7: In dual-bound mode, C is handled as follows:
  - if lower <= upper, C = (value < lower) or (value > upper);
  - otherwise, C = (value > upper) and (value < lower).
- R8: In dual-bound mode, trap equals the new C.
- R9: Flags the mode does not define keep their input values. In single-bound mode these are X, Z and V. In dual-bound mode they are X, N and V.
- R10: With done, ret_pc equals pc_in of the start cycle plus 2 in single-bound mode and plus 4 in dual-bound mode, modulo 2^PCW.
- R11: trap_vec equals parameter VEC while trap is high and is zero otherwise. trap is never high without done. A check that does not trap still gives done with trap low and updated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one check with the current inputs |
| dual_mode | input | 1 | 0 = zero/upper check, 1 = lower/upper check |
| value | input | W | Signed test value |
| lo_bound | input | W | Signed lower bound (dual-bound mode only) |
| hi_bound | input | W | Signed upper bound |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| pc_in | input | PCW | Start address of the checking instruction |
| done | output | 1 | Result valid pulse |
| trap | output | 1 | Bounds-check trap request |
| trap_vec | output | VW | Trap vector code while trap is high |
| flags_out | output | 5 | Updated flags {X,N,Z,V,C} |
| ret_pc | output | PCW | Return PC saved for the trap |

## Verification
The bench builds the unit with W = 4 and PCW = 8. At that width every combination of value, lower bound and upper bound can be swept in both modes, 8192 checks in all. Every sign combination is therefore covered: wrap-around bound pairs, equal bounds, and values at the most negative and most positive codes. The narrow PC makes the return address wrap around within the sweep, and the input flags are varied so that the unchanged flags are seen at both polarities.

// File: rtl/bound_trap_unit.sv
module bound_trap_unit #(
  parameter int unsigned W   = 32,
  parameter int unsigned PCW = 32,
  parameter int unsigned VW  = 8,
  parameter logic [VW-1:0] VEC = VW'(6)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dual_mode,
  input  logic [W-1:0]   value,
  input  logic [W-1:0]   lo_bound,
  input  logic [W-1:0]   hi_bound,
  input  logic [4:0]     flags_in,
  input  logic [PCW-1:0] pc_in,
  output logic           done,
  output logic           trap,
  output logic [VW-1:0]  trap_vec,
  output logic [4:0]     flags_out,
  output logic [PCW-1:0] ret_pc
);
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 0;

  logic signed [W-1:0] v, lo, hi;
  assign v  = value;
  assign lo = lo_bound;
  assign hi = hi_bound;

  logic v_neg, hi_neg, v_gt_hi, v_lt_lo, lo_le_hi;
  assign v_neg    = v[W-1];
  assign hi_neg   = hi[W-1];
  assign v_gt_hi  = v > hi;
  assign v_lt_lo  = v < lo;
  assign lo_le_hi = lo <= hi;

  logic s_trap, s_c, d_c, d_z, nxt_trap;
  assign s_trap = v_neg | v_gt_hi;
  assign s_c    = hi_neg ? (v_gt_hi & v_neg) : s_trap;
  assign d_c    = lo_le_hi ? (v_lt_lo | v_gt_hi) : (v_gt_hi & v_lt_lo);
  assign d_z    = (v == lo) | (v == hi);
  assign nxt_trap = dual_mode ? d_c : s_trap;

  logic [4:0] nxt_flags;
  always_comb begin
    nxt_flags = flags_in;
    if (dual_mode) begin
      nxt_flags[FZ] = d_z;
      nxt_flags[FC] = d_c;
    end else begin
      nxt_flags[FN] = v_neg;
      nxt_flags[FC] = s_c;
    end
  end

  logic           done_q, trap_q;
  logic [4:0]     flags_q;
  logic [PCW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      flags_q <= '0;
      pc_q    <= '0;
    end else begin
      done_q <= start;
      trap_q <= start & nxt_trap;
      if (start) begin
        flags_q <= nxt_flags;
        pc_q    <= pc_in + (dual_mode ? PCW'(4) : PCW'(2));
      end
    end
  end

  assign done      = done_q;
  assign trap      = trap_q;
  assign trap_vec  = trap_q ? VEC : '0;
  assign flags_out = flags_q;
  assign ret_pc    = pc_q;
endmodule

module bound_trap_unit_chk #(
  parameter int unsigned W   = 32,
  parameter int unsigned PCW = 32,
  parameter int unsigned VW  = 8,
  parameter logic [VW-1:0] VEC = VW'(6)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           dual_mode,
  input logic [W-1:0]   value,
  input logic [W-1:0]   lo_bound,
  input logic [W-1:0]   hi_bound,
  input logic [4:0]     flags_in,
  input logic [PCW-1:0] pc_in,
  input logic           done,
  input logic           trap,
  input logic [VW-1:0]  trap_vec,
  input logic [4:0]     flags_out,
  input logic [PCW-1:0] ret_pc
);
  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_trap_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done);
  p_vec_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> trap_vec == VEC);
  p_dual_trap_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dual_mode) |=> (trap == flags_out[0]));
  p_ret_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ret_pc == $past(pc_in) + ($past(dual_mode) ? PCW'(4) : PCW'(2)));
  p_keep_x_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> flags_out[4] == $past(flags_in[4]));
  p_single_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dual_mode) |=> flags_out[3] == $past(value[W-1]));
endmodule

bind bound_trap_unit bound_trap_unit_chk #(.W(W), .PCW(PCW), .VW(VW), .VEC(VEC)) chk_i (.*);

// File: tb/bound_trap_unit_tb_top.sv
module bound_trap_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int PCW = 8;
  localparam int VW = 8;
  localparam logic [VW-1:0] VEC = 8'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dual_mode = 1'b0;
  logic [W-1:0] value = '0, lo_bound = '0, hi_bound = '0;
  logic [4:0] flags_in = '0;
  logic [PCW-1:0] pc_in = '0;
  logic done, trap;
  logic [VW-1:0] trap_vec;
  logic [4:0] flags_out;
  logic [PCW-1:0] ret_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bound_trap_unit #(.W(W), .PCW(PCW), .VW(VW), .VEC(VEC)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [W-1:0] x);
    return x[W-1] ? int'(x) - (1 << W) : int'(x);
  endfunction

  task automatic run_one(input bit m, input int vi, input int li, input int hi_i);
    int sv, sl, sh, en, ez, ec, et, eflags, epc;
    logic [4:0] fin;
    logic [PCW-1:0] pc;
    fin = 5'((vi * 7 + li * 3 + hi_i * 5 + int'(m)) & 31);
    pc  = PCW'(vi * 16 + hi_i + li);
    dual_mode = m;
    value = W'(vi); lo_bound = W'(li); hi_bound = W'(hi_i);
    flags_in = fin; pc_in = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sv = sx(W'(vi)); sl = sx(W'(li)); sh = sx(W'(hi_i));
    en = int'(fin[3]); ez = int'(fin[2]);
    if (!m) begin
      en = (sv < 0) ? 1 : 0;
      et = (sv < 0 || sv > sh) ? 1 : 0;
      ec = (sh >= 0) ? et : ((sv > sh && sv < 0) ? 1 : 0);
    end else begin
      ez = (sv == sl || sv == sh) ? 1 : 0;
      ec = (sl <= sh) ? ((sv < sl || sv > sh) ? 1 : 0) : ((sv > sh && sv < sl) ? 1 : 0);
      et = ec;
    end
    eflags = (int'(fin[4]) << 4) | (en << 3) | (ez << 2) | (int'(fin[1]) << 1) | ec;
    epc = (int'(pc) + (m ? 4 : 2)) & ((1 << PCW) - 1);
    check("R2 done", int'(done), 1);
    if (!m) begin
      check("R3 N", int'(flags_out[3]), en);
      check("R4 C", int'(flags_out[0]), ec);
      check("R5 trap", int'(trap), et);
    end else begin
      check("R6 Z", int'(flags_out[2]), ez);
      check("R7 C", int'(flags_out[0]), ec);
      check("R8 trap", int'(trap), et);
    end
    check("R9 flags", int'(flags_out), eflags);
    check("R10 ret_pc", int'(ret_pc), epc);
    check("R11 vec", int'(trap_vec), et ? int'(VEC) : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 trap", int'(trap), 0);
    check("R1 vec", int'(trap_vec), 0);
    check("R1 flags", int'(flags_out), 0);
    check("R1 ret_pc", int'(ret_pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle", int'(done), 0);
    for (int m = 0; m < 2; m++)
      for (int vi = 0; vi < (1 << W); vi++)
        for (int li = 0; li < (1 << W); li++)
          for (int hi_i = 0; hi_i < (1 << W); hi_i++)
            run_one(m[0], vi, li, hi_i);
    @(negedge clk);
    check("R2 idle after", int'(done), 0);
    check("R11 no trap idle", int'(trap), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule